// File: doc/BRIEF.md
# Feature Header List Walker

This block enumerates the features of a memory-mapped register space by following a chain of 64-bit headers. After a start pulse it reads the header at the given base address through a simple read-master port. It decodes the header's type, version, revision, feature ID, end-of-list flag and link offset. For headers with a nonzero version it also fetches the register-base word and the register-size word that sit behind the GUID. It then emits one record per feature on a valid/ready stream.

The walk ends in one of two ways. It ends with `done` when a header marked end-of-list has been reported. It ends with `err` when the chain is malformed or longer than the configured limit. Only one read is in flight at any time, and the walk pauses while a record waits for the consumer. All multi-byte words are little-endian, so bit 0 is the least significant bit of the 64-bit data word.

Top module: `feat_list_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done`, `err`, `rd_req_valid` and `rec_valid` are low.
- R2: A `start` pulse while idle raises `busy` in the next cycle and clears `done` and `err`. The first read is issued to `base_addr` with its low three bits forced to zero.
- R3: Header word 0 is decoded as follows: type in bits 63:60, version in 59:52, end-of-list in bit 40, link offset in 39:16, revision in 15:12 and ID in 11:0. Each record carries these fields together with the header's own address.
- R4: A header without the end-of-list flag is followed by the header at its address plus the link offset, taken as a byte count and wrapping modulo 2^AW.
- R5: A header with version 0 is read at offset 0 only. Its record reports the header address as the register base and zero as the register size.
- R6: A header with a nonzero version causes reads at offsets 0x18 and then 0x20. If bit 0 of the 0x18 word is 1, the register base is that word with bit 0 cleared. If bit 0 is 0, the register base is the header address plus that word with bit 0 cleared. The register size is bits 63:32 of the 0x20 word.
- R7: Once the record of an end-of-list header has been accepted, `done` rises and `busy` falls in the next cycle. The link offset of that header is not checked.
- R8: A header without the end-of-list flag whose link offset is zero or not a multiple of 8 raises `err` and ends the walk. No record is produced for that header, and `done` and `err` are never high together.
- R9: If a header is reached after MAX_FEAT records have already been produced, `err` is raised and no record is produced for it. A list of exactly MAX_FEAT headers completes with `done`.
- R10: No new read request is made while a previous read is waiting for its response.
- R11: While `rec_valid` is high and `rec_ready` is low, the record fields stay unchanged and no read is issued.
- R12: A `start` pulse while `busy` is high has no effect on the walk or its records.
- R13: `done` and `err` keep their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| base_addr | input | AW | Address of the first header |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished at an end-of-list header |
| err | output | 1 | Walk stopped on a malformed or overlong list |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Byte address of the 64-bit read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 64 | Read data |
| rec_valid | output | 1 | Record valid |
| rec_ready | input | 1 | Record accepted |
| rec_hdr_addr | output | AW | Address of the header |
| rec_type | output | 4 | Header type |
| rec_ver | output | 8 | Header version |
| rec_rev | output | 4 | Feature revision |
| rec_id | output | 12 | Feature ID |
| rec_reg_base | output | AW | Resolved register base |
| rec_reg_size | output | 32 | Register-set size (0 for version 0) |

## Verification
The walker is run over a mixed chain that combines version-0 and extended headers, absolute and relative register bases, and a terminal header with an odd link value. This separates correct field decoding and base resolution from a mix-up of the two address forms. The same chain is then run with random request back-pressure, response latency, output stalls and a stray start pulse, which shows whether ordering, holding and the one-read rule survive timing changes. Short chains probe each ending: a zero link, a misaligned link, one header past the limit, exactly the limit, a misaligned base, and a link that wraps the address space. Each case shows whether the walk stops at the right header and with the right flag.

// File: rtl/feat_list_walker.sv
module feat_list_walker #(
  parameter int AW       = 48,
  parameter int MAX_FEAT = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  input  logic [63:0]   rd_rsp_data,
  output logic          rec_valid,
  input  logic          rec_ready,
  output logic [AW-1:0] rec_hdr_addr,
  output logic [3:0]    rec_type,
  output logic [7:0]    rec_ver,
  output logic [3:0]    rec_rev,
  output logic [11:0]   rec_id,
  output logic [AW-1:0] rec_reg_base,
  output logic [31:0]   rec_reg_size
);

  localparam int CW = $clog2(MAX_FEAT + 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_EMIT} st_t;

  st_t          st;
  logic [2:0]   widx;
  logic         eol;
  logic [23:0]  nxt;
  logic [CW-1:0] cnt;

  // AW is at most 64; the address word keeps bits AW-1:1
  wire [AW-1:0] addr_word = {rd_rsp_data[AW-1:1], 1'b0};
  wire          link_bad  = (rd_rsp_data[39:16] == 24'd0) || (rd_rsp_data[18:16] != 3'd0);
  wire          at_limit  = (cnt == CW'(MAX_FEAT));

  assign busy         = (st != S_IDLE);
  assign rd_req_valid = (st == S_REQ);
  assign rec_valid    = (st == S_EMIT);
  assign rd_req_addr  = rec_hdr_addr + AW'({widx, 3'b000});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      done         <= 1'b0;
      err          <= 1'b0;
      widx         <= '0;
      eol          <= 1'b0;
      nxt          <= '0;
      cnt          <= '0;
      rec_hdr_addr <= '0;
      rec_type     <= '0;
      rec_ver      <= '0;
      rec_rev      <= '0;
      rec_id       <= '0;
      rec_reg_base <= '0;
      rec_reg_size <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          rec_hdr_addr <= {base_addr[AW-1:3], 3'b000};
          widx         <= '0;
          cnt          <= '0;
          done         <= 1'b0;
          err          <= 1'b0;
          st           <= S_REQ;
        end
        S_REQ: if (rd_req_ready) st <= S_WAIT;
        S_WAIT: if (rd_rsp_valid) begin
          unique case (widx)
            3'd0: begin
              rec_type <= rd_rsp_data[63:60];
              rec_ver  <= rd_rsp_data[59:52];
              eol      <= rd_rsp_data[40];
              nxt      <= rd_rsp_data[39:16];
              rec_rev  <= rd_rsp_data[15:12];
              rec_id   <= rd_rsp_data[11:0];
              if (at_limit || (!rd_rsp_data[40] && link_bad)) begin
                err <= 1'b1;
                st  <= S_IDLE;
              end else if (rd_rsp_data[59:52] == 8'd0) begin
                rec_reg_base <= rec_hdr_addr;
                rec_reg_size <= '0;
                st           <= S_EMIT;
              end else begin
                widx <= 3'd3;
                st   <= S_REQ;
              end
            end
            3'd3: begin
              rec_reg_base <= rd_rsp_data[0] ? addr_word : rec_hdr_addr + addr_word;
              widx         <= 3'd4;
              st           <= S_REQ;
            end
            default: begin
              rec_reg_size <= rd_rsp_data[63:32];
              st           <= S_EMIT;
            end
          endcase
        end
        S_EMIT: if (rec_ready) begin
          cnt <= cnt + 1'b1;
          if (eol) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            rec_hdr_addr <= rec_hdr_addr + AW'(nxt);
            widx         <= '0;
            st           <= S_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/feat_list_walker_chk.sv
module feat_list_walker_chk #(
  parameter int AW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          rd_req_valid,
  input logic          rd_req_ready,
  input logic          rd_rsp_valid,
  input logic          rec_valid,
  input logic          rec_ready,
  input logic [AW-1:0] rec_hdr_addr,
  input logic [AW-1:0] rec_reg_base
);

  logic outst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            outst <= 1'b0;
    else if (rd_req_valid && rd_req_ready) outst <= 1'b1;
    else if (rd_rsp_valid)                 outst <= 1'b0;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && !err && !rd_req_valid && !rec_valid));

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && !err));

  assert_one_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    outst |-> !rd_req_valid);

  assert_record_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_hdr_addr) && $stable(rec_reg_base)));

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  assert_flags_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !busy);

  assert_flags_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ((done || err) && !start) |=> ($stable(done) && $stable(err)));

endmodule

bind feat_list_walker feat_list_walker_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_rsp_valid(rd_rsp_valid),
  .rec_valid(rec_valid), .rec_ready(rec_ready),
  .rec_hdr_addr(rec_hdr_addr), .rec_reg_base(rec_reg_base)
);

// File: tb/feat_list_walker_tb_top.sv
module feat_list_walker_tb_top;
  localparam int AW   = 48;
  localparam int MAXF = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          busy, done, err;
  logic          rd_req_valid;
  logic          rd_req_ready = 1'b0;
  logic [AW-1:0] rd_req_addr;
  logic          rd_rsp_valid = 1'b0;
  logic [63:0]   rd_rsp_data = '0;
  logic          rec_valid;
  logic          rec_ready = 1'b0;
  logic [AW-1:0] rec_hdr_addr, rec_reg_base;
  logic [3:0]    rec_type, rec_rev;
  logic [7:0]    rec_ver;
  logic [11:0]   rec_id;
  logic [31:0]   rec_reg_size;

  feat_list_walker #(.AW(AW), .MAX_FEAT(MAXF)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .busy(busy), .done(done), .err(err),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_hdr_addr(rec_hdr_addr),
    .rec_type(rec_type), .rec_ver(rec_ver), .rec_rev(rec_rev), .rec_id(rec_id),
    .rec_reg_base(rec_reg_base), .rec_reg_size(rec_reg_size)
  );

  typedef struct packed {
    logic [47:0] ha; logic [3:0] ty; logic [7:0] ve; logic [3:0] rv;
    logic [11:0] id; logic [47:0] rb; logic [31:0] sz;
  } rec_t;

  logic [63:0] mem [logic [47:0]];
  rec_t        expq[$];
  logic [47:0] addrq[$];
  bit          exp_err;
  int          errors = 0;
  int          checks = 0;
  bit          finished = 0;
  int          lat_max = 0, rdy_pct = 100, out_pct = 100;

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic logic [63:0] rdm(input logic [47:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  task automatic put_hdr(input logic [47:0] a, input logic [3:0] ty, input logic [7:0] ve,
                         input bit eo, input logic [23:0] nx, input logic [3:0] rv, input logic [11:0] id);
    mem[a] = {ty, ve, 11'h0, eo, nx, rv, id};
  endtask

  task automatic put_ext(input logic [47:0] a, input logic [63:0] w3, input logic [63:0] w4);
    mem[a + 48'd24] = w3;
    mem[a + 48'd32] = w4;
  endtask

  // behavioural walk of the list held in mem
  function automatic void model(input logic [47:0] base);
    logic [47:0] h;
    logic [63:0] w, w3, w4;
    rec_t r;
    int n;
    h = {base[47:3], 3'b000};
    n = 0;
    expq.delete();
    addrq.delete();
    exp_err = 0;
    while (1) begin
      w = rdm(h);
      addrq.push_back(h);
      if (n == MAXF) begin exp_err = 1; return; end
      if (!w[40] && (w[39:16] == 0 || w[18:16] != 0)) begin exp_err = 1; return; end
      r.ha = h; r.ty = w[63:60]; r.ve = w[59:52]; r.rv = w[15:12]; r.id = w[11:0];
      if (w[59:52] == 0) begin
        r.rb = h; r.sz = 0;
      end else begin
        addrq.push_back(h + 48'd24);
        addrq.push_back(h + 48'd32);
        w3 = rdm(h + 48'd24);
        w4 = rdm(h + 48'd32);
        r.rb = w3[0] ? {w3[47:1], 1'b0} : h + {w3[47:1], 1'b0};
        r.sz = w4[63:32];
      end
      expq.push_back(r);
      n++;
      if (w[40]) return;
      h = h + {24'h0, w[39:16]};
    end
  endfunction

  // memory responder, stream consumer and per-cycle comparison
  initial begin : drive
    bit          pend = 0;
    int          pcnt = 0;
    logic [47:0] paddr = '0;
    bit          stalled = 0;
    rec_t        last = '0;
    rec_t        cur;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        rd_rsp_valid = 1'b0;
        check(!(pend && rd_req_valid), "R10 request while read pending act=1 exp=0");
        if (pend) begin
          if (pcnt == 0) begin
            rd_rsp_valid = 1'b1;
            rd_rsp_data  = rdm(paddr);
            pend = 0;
          end else pcnt--;
        end
        rd_req_ready = ($urandom_range(99) < rdy_pct);
        if (rd_req_valid && rd_req_ready) begin
          if (addrq.size() == 0)
            check(0, $sformatf("R5 R6 unexpected read act=%h exp=none", rd_req_addr));
          else begin
            check(rd_req_addr == addrq[0],
                  $sformatf("R2 R4 R5 R6 read address act=%h exp=%h", rd_req_addr, addrq[0]));
            void'(addrq.pop_front());
          end
          pend  = 1;
          pcnt  = $urandom_range(lat_max);
          paddr = rd_req_addr;
        end
        cur = '{rec_hdr_addr, rec_type, rec_ver, rec_rev, rec_id, rec_reg_base, rec_reg_size};
        if (stalled) begin
          check(rec_valid && cur == last,
                $sformatf("R11 stalled record act=%h exp=%h", cur, last));
          stalled = 0;
        end
        if (rec_valid)
          check(!rd_req_valid, "R11 read during pending record act=1 exp=0");
        rec_ready = ($urandom_range(99) < out_pct);
        if (rec_valid) begin
          if (rec_ready) begin
            if (expq.size() == 0)
              check(0, $sformatf("R7 R8 R9 unexpected record act=%h exp=none", cur));
            else begin
              check(cur == expq[0],
                    $sformatf("R3 R5 R6 record act=%h exp=%h", cur, expq[0]));
              void'(expq.pop_front());
            end
          end else begin
            stalled = 1;
            last    = cur;
          end
        end
      end
    end
  end

  task automatic run_walk(input logic [47:0] base, input int lat, input int rp, input int op,
                          input int poke, input string tag);
    int k;
    model(base);
    lat_max = lat; rdy_pct = rp; out_pct = op;
    @(negedge clk);
    start = 1'b1; base_addr = base;
    @(negedge clk);
    start = 1'b0;
    check(busy && !done && !err,
          $sformatf("R2 after start busy/done/err act=%b%b%b exp=100", busy, done, err));
    k = 0;
    while (busy) begin
      @(negedge clk);
      k++;
      if (poke > 0 && k == poke) begin start = 1'b1; base_addr = 48'h9990; end
      if (poke > 0 && k == poke + 1) start = 1'b0;
    end
    start = 1'b0;
    check(done == !exp_err && err == exp_err,
          $sformatf("%s end flags done/err act=%b%b exp=%b%b", tag, done, err, !exp_err, exp_err));
    check(expq.size() == 0 && addrq.size() == 0,
          $sformatf("%s leftover records/reads act=%0d/%0d exp=0/0", tag, expq.size(), addrq.size()));
    repeat (3) @(negedge clk);
    check(done == !exp_err && err == exp_err && !busy,
          $sformatf("R13 flags held act=%b%b%b exp=%b%b0", done, err, busy, !exp_err, exp_err));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired act=running exp=finished");
    report();
  end

  initial begin : main
    repeat (2) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !err && !rd_req_valid && !rec_valid,
          $sformatf("R1 reset outputs act=%b%b%b%b%b exp=00000", busy, done, err, rd_req_valid, rec_valid));
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !rd_req_valid && !rec_valid, "R1 idle after reset act=active exp=idle");

    // mixed chain: relative, version 0, absolute, nonzero version with odd terminal link
    mem.delete();
    put_hdr(48'h1000, 4'h4, 8'd1, 0, 24'h40, 4'h1, 12'h012);
    put_ext(48'h1000, 64'h0000_0000_0000_0200, {32'h0000_0100, 32'h8003_0001});
    put_hdr(48'h1040, 4'h3, 8'd0, 0, 24'h1000, 4'h2, 12'hABC);
    put_hdr(48'h2040, 4'h3, 8'd1, 0, 24'h38, 4'hF, 12'h007);
    put_ext(48'h2040, 64'h0000_00AB_CDE0_0001, {32'h0000_4000, 32'h8001_0002});
    put_hdr(48'h2078, 4'h1, 8'd2, 1, 24'h123, 4'h5, 12'hFFF);
    put_ext(48'h2078, 64'h0000_0000_0000_0007, {32'h0000_0010, 32'h0});
    run_walk(48'h1000, 0, 100, 100, 0, "R4 R6 R7 mixed chain");
    // same chain under back-pressure, latency and a stray start (R12)
    run_walk(48'h1000, 3, 50, 40, 4, "R11 R12 stalled chain");

    // single terminal header, misaligned base
    mem.delete();
    put_hdr(48'h8000, 4'h2, 8'd0, 1, 24'h5, 4'h0, 12'h100);
    run_walk(48'h8005, 1, 70, 70, 0, "R2 R7 single terminal");

    // zero link after one record
    mem.delete();
    put_hdr(48'h3000, 4'h3, 8'd0, 0, 24'h10, 4'h1, 12'h001);
    put_hdr(48'h3010, 4'h3, 8'd0, 0, 24'h0, 4'h1, 12'h002);
    run_walk(48'h3000, 0, 100, 100, 0, "R8 zero link");

    // misaligned link at the first header
    mem.delete();
    put_hdr(48'h4000, 4'h3, 8'd0, 0, 24'h14, 4'h1, 12'h003);
    run_walk(48'h4000, 0, 100, 100, 0, "R8 misaligned link");

    // one header past the limit
    mem.delete();
    for (int i = 0; i <= MAXF; i++)
      put_hdr(48'h5000 + 48'(8 * i), 4'h3, 8'd0, (i == MAXF), 24'h8, 4'(i), 12'(i));
    run_walk(48'h5000, 1, 80, 80, 0, "R9 over limit");

    // exactly the limit
    mem.delete();
    for (int i = 0; i < MAXF; i++)
      put_hdr(48'h6000 + 48'(8 * i), 4'h3, 8'd0, (i == MAXF - 1), 24'h8, 4'(i), 12'(i));
    run_walk(48'h6000, 0, 100, 100, 0, "R9 at limit");

    // link wraps the address space
    mem.delete();
    put_hdr(48'hFFFF_FFFF_FFF8, 4'h3, 8'd0, 0, 24'h10, 4'h1, 12'h0AA);
    put_hdr(48'h0000_0000_0008, 4'h3, 8'd0, 1, 24'h8, 4'h1, 12'h0BB);
    run_walk(48'hFFFF_FFFF_FFF8, 0, 100, 100, 0, "R4 wrap");

    report();
  end

endmodule